// File: doc/BRIEF.md
# Paged register table selector

This block sits behind a byte-addressed serial slave front end and decides which storage answers each access. The 256-byte address space is split in two. Addresses 00h to 7Eh are a flat lower area, which includes a four-byte password field at 7Bh to 7Eh. Address 7Fh holds a table number. That number chooses which numbered table shows through the upper window at 80h to FFh.

Four table numbers map storage: 01h, 02h, 04h and 05h. The other 252 numbers, including 00h, map nothing. Empty or unmapped locations read as 00h, and writes to them are dropped. An eight-byte alarm-enable row occupies F8h to FFh. It belongs to table 01h or to table 05h, depending on a mask bit held in configuration byte 89h of table 02h. The same eight bytes of storage serve both views.

Reads are registered. Read data appears one cycle after the read strobe, together with a valid pulse, and is held until the next read.

Top module: `paged_regmap`

## Requirements
- R1: After a synchronous reset the table-select byte is 00h, configuration byte 89h of table 02h is 00h (so the mask bit is clear), `rd_data` is 00h and `rd_valid` is low.
- R2: Addresses 00h to 7Eh, including the password bytes 7Bh to 7Eh, are read/write storage. They are independent of the table-select value.
- R3: Address 7Fh is the table-select byte. It is readable and writable at any time, and a read returns the last value written.
- R4: When the table-select byte is any value other than 01h, 02h, 04h or 05h (00h included), reads of 80h to FFh return 00h. Writes there change no storage in any table.
- R5: With table 01h selected, 80h to F7h are 120 read/write bytes.
- R6: With table 02h selected, 80h to F7h are 120 read/write bytes. Bit 0 of byte 89h is the mask bit. F8h to FFh are empty.
- R7: With table 04h selected, 80h to C7h are 72 read/write bytes, and C8h to FFh are empty.
- R8: With the mask bit at 0, the alarm-enable row is read/write at F8h to FFh of table 01h. All of table 05h is empty.
- R9: With the mask bit at 1, the alarm-enable row is read/write at F8h to FFh of table 05h. Table 01h is empty at F8h to FFh, and table 05h is empty at 80h to F7h.
- R10: Both views of the alarm-enable row share one storage, so bytes written through one view read back through the other after the mask bit changes.
- R11: Read data for a strobe in cycle n appears on `rd_data` with `rd_valid` high in cycle n+1. `rd_data` then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the access |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | High in the cycle `rd_data` carries a new byte |

## Verification
The hardest behaviour to reach from the ports is a dropped write. A write to an empty location can only be seen through what it failed to change, in some other table reached through another select value. Each sweep therefore writes every upper address under all ten select values before it reads any of them back. A write that leaked into real storage then shows up as a miscompare in the table it corrupted. The mask bit can only be moved by writing table 02h. So both mask settings are set up through that table, and the sweep forces the mask bit in its own pattern byte so that the sweep keeps the chosen setting.

// File: rtl/paged_regmap_pkg.sv
package paged_regmap_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_LOW,
    RG_SEL,
    RG_T1,
    RG_T2,
    RG_MASK,
    RG_T4,
    RG_ROW
  } region_e;
endpackage

// File: rtl/paged_regmap_ram.sv
module paged_regmap_ram #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/paged_regmap_decode.sv
module paged_regmap_decode
  import paged_regmap_pkg::*;
#(
  parameter int          T1_LEN   = 120,
  parameter int          T2_LEN   = 120,
  parameter int          T4_LEN   = 72,
  parameter int          ROW_LEN  = 8,
  parameter logic [7:0]  SEL_ADDR = 8'h7F,
  parameter logic [7:0]  CFG_ADDR = 8'h89
) (
  input  logic [7:0] addr,
  input  logic [7:0] sel,
  input  logic       mask,
  output region_e    region,
  output logic [6:0] idx
);
  localparam int         ROW_OFF  = 128 - ROW_LEN;
  localparam logic [6:0] CFG_OFF  = CFG_ADDR[6:0];
  localparam logic [6:0] ROW_OFF7 = 7'(ROW_OFF);

  logic [6:0] off;
  logic       in_row;

  assign off    = addr[6:0];
  assign in_row = (int'(off) >= ROW_OFF);

  always_comb begin
    region = RG_NONE;
    idx    = off;
    if (!addr[7]) begin
      region = (addr == SEL_ADDR) ? RG_SEL : RG_LOW;
    end else begin
      case (sel)
        8'h01: begin
          if (int'(off) < T1_LEN) region = RG_T1;
          else if (in_row && !mask) begin
            region = RG_ROW;
            idx    = off - ROW_OFF7;
          end
        end
        8'h02: begin
          if (off == CFG_OFF) region = RG_MASK;
          else if (int'(off) < T2_LEN) region = RG_T2;
        end
        8'h04: if (int'(off) < T4_LEN) region = RG_T4;
        8'h05: begin
          if (in_row && mask) begin
            region = RG_ROW;
            idx    = off - ROW_OFF7;
          end
        end
        default: region = RG_NONE;
      endcase
    end
  end

  always_comb begin
    if (region == RG_ROW) begin
      // R8
      row_home_chk: assert ((sel == 8'h01 && !mask) || (sel == 8'h05 && mask));
      // R9
      row_place_chk: assert (int'(idx) < ROW_LEN && addr[7]);
    end
    if (region == RG_T4) begin
      // R7
      t4_bound_chk: assert (int'(idx) < T4_LEN);
    end
  end
endmodule

// File: rtl/paged_regmap.sv
module paged_regmap
  import paged_regmap_pkg::*;
#(
  parameter int          T1_LEN   = 120,
  parameter int          T2_LEN   = 120,
  parameter int          T4_LEN   = 72,
  parameter int          ROW_LEN  = 8,
  parameter logic [7:0]  SEL_ADDR = 8'h7F,
  parameter logic [7:0]  CFG_ADDR = 8'h89,
  parameter int          MASK_BIT = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  localparam int LO_LEN = 128;
  localparam int LO_IW  = $clog2(LO_LEN);
  localparam int T1_IW  = $clog2(T1_LEN);
  localparam int T2_IW  = $clog2(T2_LEN);
  localparam int T4_IW  = $clog2(T4_LEN);
  localparam int RW_IW  = $clog2(ROW_LEN);

  region_e    region, region_q;
  logic [6:0] idx;
  logic [7:0] sel_q, cfg_q, sel_rd_q, cfg_rd_q;
  logic       mask;
  logic [7:0] lo_rd, t1_rd, t2_rd, t4_rd, row_rd;

  assign mask = cfg_q[MASK_BIT];

  paged_regmap_decode #(
    .T1_LEN(T1_LEN), .T2_LEN(T2_LEN), .T4_LEN(T4_LEN), .ROW_LEN(ROW_LEN),
    .SEL_ADDR(SEL_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_dec (
    .addr(addr), .sel(sel_q), .mask(mask), .region(region), .idx(idx)
  );

  paged_regmap_ram #(.DEPTH(LO_LEN)) u_lo (
    .clk(clk), .we(wr_en && region == RG_LOW), .re(rd_en),
    .idx(idx[LO_IW-1:0]), .wdata(wr_data), .rdata(lo_rd));

  paged_regmap_ram #(.DEPTH(T1_LEN)) u_t1 (
    .clk(clk), .we(wr_en && region == RG_T1), .re(rd_en),
    .idx(idx[T1_IW-1:0]), .wdata(wr_data), .rdata(t1_rd));

  paged_regmap_ram #(.DEPTH(T2_LEN)) u_t2 (
    .clk(clk), .we(wr_en && region == RG_T2), .re(rd_en),
    .idx(idx[T2_IW-1:0]), .wdata(wr_data), .rdata(t2_rd));

  paged_regmap_ram #(.DEPTH(T4_LEN)) u_t4 (
    .clk(clk), .we(wr_en && region == RG_T4), .re(rd_en),
    .idx(idx[T4_IW-1:0]), .wdata(wr_data), .rdata(t4_rd));

  paged_regmap_ram #(.DEPTH(ROW_LEN)) u_row (
    .clk(clk), .we(wr_en && region == RG_ROW), .re(rd_en),
    .idx(idx[RW_IW-1:0]), .wdata(wr_data), .rdata(row_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 8'h00;
      cfg_q    <= 8'h00;
      sel_rd_q <= 8'h00;
      cfg_rd_q <= 8'h00;
      region_q <= RG_NONE;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        region_q <= region;
        sel_rd_q <= sel_q;
        cfg_rd_q <= cfg_q;
      end
      if (wr_en && region == RG_SEL)  sel_q <= wr_data;
      if (wr_en && region == RG_MASK) cfg_q <= wr_data;
    end
  end

  always_comb begin
    case (region_q)
      RG_LOW:  rd_data = lo_rd;
      RG_SEL:  rd_data = sel_rd_q;
      RG_T1:   rd_data = t1_rd;
      RG_T2:   rd_data = t2_rd;
      RG_MASK: rd_data = cfg_rd_q;
      RG_T4:   rd_data = t4_rd;
      RG_ROW:  rd_data = row_rd;
      default: rd_data = 8'h00;
    endcase
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (sel_q == 8'h00 && !mask && !rd_valid));

  // R3
  sel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_ADDR) |=> (sel_q == $past(wr_data)));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && region == RG_NONE) |=> (rd_data == 8'h00));

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rd_en)) |-> $stable(rd_data));
endmodule

// File: tb/tb_paged_regmap.sv
module tb_paged_regmap;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [128];
  logic [7:0] m_t1 [120];
  logic [7:0] m_t2 [120];
  logic [7:0] m_t4 [72];
  logic [7:0] m_row [8];
  logic [7:0] m_sel = 8'h00;
  logic [7:0] m_cfg = 8'h00;

  always #10 clk = ~clk;

  paged_regmap dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input logic [7:0] a);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%02h sel=%02h actual=%02h expected=%02h", req, a, m_sel, act, exp);
    end
  endtask

  function automatic void mdl_write(input logic [7:0] a, input logic [7:0] d);
    int off;
    off = int'(a) - 128;
    if (a == 8'h7F) m_sel = d;
    else if (a < 8'h80) m_lo[a[6:0]] = d;
    else begin
      case (m_sel)
        8'h01: if (off < 120) m_t1[off] = d;
               else if (!m_cfg[0]) m_row[off-120] = d;
        8'h02: if (off == 9) m_cfg = d;
               else if (off < 120) m_t2[off] = d;
        8'h04: if (off < 72) m_t4[off] = d;
        8'h05: if (off >= 120 && m_cfg[0]) m_row[off-120] = d;
        default: ;
      endcase
    end
  endfunction

  function automatic logic [7:0] mdl_read(input logic [7:0] a);
    int off;
    off = int'(a) - 128;
    if (a == 8'h7F) return m_sel;
    if (a < 8'h80) return m_lo[a[6:0]];
    case (m_sel)
      8'h01: if (off < 120) return m_t1[off];
             else if (!m_cfg[0]) return m_row[off-120];
      8'h02: if (off == 9) return m_cfg;
             else if (off < 120) return m_t2[off];
      8'h04: if (off < 72) return m_t4[off];
      8'h05: if (off >= 120 && m_cfg[0]) return m_row[off-120];
      default: ;
    endcase
    return 8'h00;
  endfunction

  function automatic string req_of(input logic [7:0] a);
    int off;
    off = int'(a) - 128;
    if (a < 8'h7F) return "R2";
    if (a == 8'h7F) return "R3";
    case (m_sel)
      8'h01: return (off < 120) ? "R5" : (m_cfg[0] ? "R9" : "R8");
      8'h02: return "R6";
      8'h04: return "R7";
      8'h05: return (off >= 120 && !m_cfg[0]) ? "R8" : "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [7:0] exp;
    exp = mdl_read(a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R11", {7'd0, rd_valid}, 8'h01, a);
    check(req_of(a), rd_data, exp, a);
    @(negedge clk);
    // R11: data held one cycle after the strobe
    check("R11", rd_data, exp, a);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] sels [10];
    sels = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'hFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", rd_data, 8'h00, 8'h00);
    check("R1", {7'd0, rd_valid}, 8'h00, 8'h00);
    do_read(8'h7F);
    do_write(8'h7F, 8'h02);
    do_read(8'h89);

    // R2: lower area, password bytes included
    for (int a = 0; a < 127; a++) do_write(8'(a), 8'(a * 7 + 3));
    for (int a = 0; a < 127; a++) do_read(8'(a));

    for (int mk = 0; mk < 2; mk++) begin
      do_write(8'h7F, 8'h02);
      do_write(8'h89, {7'h55, mk[0]});
      for (int s = 0; s < 10; s++) begin
        do_write(8'h7F, sels[s]);
        for (int a = 128; a < 256; a++) begin
          logic [7:0] d;
          d = 8'(a) ^ 8'(int'(sels[s]) * 37) ^ (mk[0] ? 8'hA5 : 8'h3C);
          if (sels[s] == 8'h02 && a == 8'h89) d[0] = mk[0];
          do_write(8'(a), d);
        end
      end
      for (int s = 0; s < 10; s++) begin
        do_write(8'h7F, sels[s]);
        do_read(8'h7F);
        for (int a = 128; a < 256; a++) do_read(8'(a));
      end
    end

    // R10: row written with mask 0 via table 01h, read via table 05h with mask 1
    do_write(8'h7F, 8'h02);
    do_write(8'h89, 8'h00);
    do_write(8'h7F, 8'h01);
    for (int a = 248; a < 256; a++) do_write(8'(a), 8'(a * 3));
    do_write(8'h7F, 8'h02);
    do_write(8'h89, 8'h01);
    do_write(8'h7F, 8'h05);
    for (int a = 248; a < 256; a++) begin
      @(negedge clk);
      addr = 8'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R10", rd_data, 8'(a * 3), 8'(a));
    end

    // R2: lower area unaffected by all the paged traffic
    for (int a = 120; a < 127; a++) do_read(8'(a));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule